// File: doc/BRIEF.md
# Dual-Width Architectural Register File

This block holds the architectural integer state of a 64-bit load/store core: thirty-one general-purpose 64-bit registers, a stack pointer kept apart from that array, and a constant-zero source. Two read ports and one write port serve the execute stage. Every access carries a narrow flag. When it is set, the access uses only the lower 32-bit half of the register, and a narrow write clears the upper half.

A 5-bit specifier picks the register. Values 0 to 30 name the general-purpose registers. Value 31 is shared: a per-port context bit decides whether it names the stack pointer or the zero source. Each read port can also return the program counter, which comes in as an input. That value is read-only because the write port has no path to it. Reads are combinational. A write lands on the rising edge, so a read of the register being written in the same cycle still returns the old contents.

Top module: `gp_regfile`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) clears all 31 general-purpose registers and the stack pointer to zero.
- R2: A wide write (wr_narrow=0) to specifier 0..30 stores all 64 bits of wr_data. The new value is readable from the cycle after the edge.
- R3: A narrow write (wr_narrow=1) stores wr_data[31:0] into bits 31:0 and sets bits 63:32 of the target to zero.
- R4: A narrow read (rd_narrow=1) returns the selected value's bits 31:0 with bits 63:32 of the output at zero. A wide read returns all 64 bits.
- R5: Specifier 31 with the context bit 0 reads as 0. A write to it has no effect on any register.
- R6: Specifier 31 with the context bit 1 accesses the stack pointer. Stack pointer writes leave the general-purpose registers unchanged, and writes to 0..30 leave the stack pointer unchanged.
- R7: A read port with rd_pc=1 returns pc_value, subject to its narrow flag. No write changes that value.
- R8: Nothing is written when wr_en is low at the rising edge.
- R9: A read of the register being written in the same cycle returns the value held before the edge.
- R10: The two read ports select, narrow and return values independently of each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 5 | Write register specifier |
| wr_sp_ctx | input | 1 | Specifier 31 means stack pointer (1) or zero source (0) |
| wr_narrow | input | 1 | 1: 32-bit view, 0: 64-bit view |
| wr_data | input | 64 | Write data |
| pc_value | input | 64 | Current program counter, read-only |
| a_idx | input | 5 | Port A specifier |
| a_sp_ctx | input | 1 | Port A context bit for specifier 31 |
| a_narrow | input | 1 | Port A 32-bit view |
| a_pc | input | 1 | Port A returns pc_value |
| a_data | output | 64 | Port A read data |
| b_idx | input | 5 | Port B specifier |
| b_sp_ctx | input | 1 | Port B context bit for specifier 31 |
| b_narrow | input | 1 | Port B 32-bit view |
| b_pc | input | 1 | Port B returns pc_value |
| b_data | output | 64 | Port B read data |

## Verification
Read data is due in the same cycle as its selects because the read path has no register. A write changes read data only from the first cycle after its rising edge. The bench applies every input at the falling edge and compares both ports 1 ns later, before the next rising edge, so it sees the state from before any write in that cycle. Its reference model updates its own arrays after the rising edge, so each comparison sees exactly the writes from earlier cycles. That placement tests the old-value rule for same-cycle reads and the one-cycle write latency.

// File: rtl/gp_regfile_pkg.sv
package gp_regfile_pkg;

    localparam int XLEN     = 64;
    localparam int HALF     = XLEN / 2;
    localparam int NUM_GPR  = 31;
    localparam int IDX_W    = $clog2(NUM_GPR + 1);
    localparam int SHARED_IDX = NUM_GPR;

    typedef logic [XLEN-1:0] word_t;
    typedef logic [NUM_GPR-1:0][XLEN-1:0] gpr_bank_t;

    typedef enum logic [1:0] {
        SRC_GPR  = 2'd0,
        SRC_ZERO = 2'd1,
        SRC_SP   = 2'd2,
        SRC_PC   = 2'd3
    } rd_src_e;

    typedef struct packed {
        logic             en;
        logic [IDX_W-1:0] idx;
        logic             sp_ctx;
        logic             narrow;
        word_t            data;
    } wr_req_t;

    typedef struct packed {
        logic [IDX_W-1:0] idx;
        logic             sp_ctx;
        logic             narrow;
        logic             pc;
    } rd_req_t;

    // Apply the view width: the narrow view keeps the low half only.
    function automatic word_t fit_view(input logic narrow, input word_t v);
        word_t r;
        r = v;
        if (narrow) r[XLEN-1:HALF] = '0;
        return r;
    endfunction

    function automatic rd_src_e classify(input rd_req_t q);
        if (q.pc) return SRC_PC;
        if (q.idx == IDX_W'(SHARED_IDX)) return q.sp_ctx ? SRC_SP : SRC_ZERO;
        return SRC_GPR;
    endfunction

endpackage

// File: rtl/gp_regfile_wr_decode.sv
module gp_regfile_wr_decode
    import gp_regfile_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  wr_req_t            req,
    output logic [NUM_GPR-1:0] gpr_we,
    output logic               sp_we,
    output word_t              wr_val
);

    for (genvar i = 0; i < NUM_GPR; i++) begin : g_sel
        assign gpr_we[i] = req.en && (req.idx == IDX_W'(i));
    end

    assign sp_we  = req.en && (req.idx == IDX_W'(SHARED_IDX)) && req.sp_ctx;
    assign wr_val = fit_view(req.narrow, req.data);

    // At most one destination per write.
    p_single_target_r6: assert property (@(posedge clk) disable iff (rst)
        $onehot0({sp_we, gpr_we}));

    // Zero-source writes reach no register.
    p_zero_write_dropped_r5: assert property (@(posedge clk) disable iff (rst)
        (req.en && req.idx == IDX_W'(SHARED_IDX) && !req.sp_ctx) |-> (gpr_we == '0 && !sp_we));

    // Disabled writes reach no register.
    p_no_write_when_idle_r8: assert property (@(posedge clk) disable iff (rst)
        !req.en |-> (gpr_we == '0 && !sp_we));

endmodule

// File: rtl/gp_regfile_storage.sv
module gp_regfile_storage
    import gp_regfile_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_GPR-1:0] gpr_we,
    input  logic               sp_we,
    input  logic               narrow,
    input  word_t              wr_val,
    output gpr_bank_t          gpr_q,
    output word_t              sp_q
);

    for (genvar i = 0; i < NUM_GPR; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)            gpr_q[i] <= '0;
            else if (gpr_we[i]) gpr_q[i] <= wr_val;
        end

        p_gpr_hold_r8: assert property (@(posedge clk) disable iff (rst)
            !gpr_we[i] |=> $stable(gpr_q[i]));

        p_gpr_load_r2: assert property (@(posedge clk) disable iff (rst)
            gpr_we[i] |=> gpr_q[i] == $past(wr_val));

        p_gpr_upper_clear_r3: assert property (@(posedge clk) disable iff (rst)
            (gpr_we[i] && narrow) |=> gpr_q[i][XLEN-1:HALF] == '0);
    end

    always_ff @(posedge clk) begin
        if (rst)        sp_q <= '0;
        else if (sp_we) sp_q <= wr_val;
    end

    p_sp_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !sp_we |=> $stable(sp_q));

    p_sp_upper_clear_r3: assert property (@(posedge clk) disable iff (rst)
        (sp_we && narrow) |=> sp_q[XLEN-1:HALF] == '0);

endmodule

// File: rtl/gp_regfile_rd_port.sv
module gp_regfile_rd_port
    import gp_regfile_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  rd_req_t   req,
    input  gpr_bank_t gpr_q,
    input  word_t     sp_q,
    input  word_t     pc_value,
    output word_t     data
);

    rd_src_e src;
    word_t   raw;

    always_comb begin
        src = classify(req);
        unique case (src)
            SRC_GPR:  raw = gpr_q[req.idx];
            SRC_SP:   raw = sp_q;
            SRC_PC:   raw = pc_value;
            default:  raw = '0;
        endcase
        data = fit_view(req.narrow, raw);
    end

    p_narrow_upper_zero_r4: assert property (@(posedge clk) disable iff (rst)
        req.narrow |-> data[XLEN-1:HALF] == '0);

    p_zero_source_r5: assert property (@(posedge clk) disable iff (rst)
        (!req.pc && req.idx == IDX_W'(SHARED_IDX) && !req.sp_ctx) |-> data == '0);

    p_pc_wide_r7: assert property (@(posedge clk) disable iff (rst)
        (req.pc && !req.narrow) |-> data == pc_value);

endmodule

// File: rtl/gp_regfile.sv
module gp_regfile
    import gp_regfile_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_sp_ctx,
    input  logic             wr_narrow,
    input  logic [XLEN-1:0]  wr_data,
    input  logic [XLEN-1:0]  pc_value,
    input  logic [IDX_W-1:0] a_idx,
    input  logic             a_sp_ctx,
    input  logic             a_narrow,
    input  logic             a_pc,
    output logic [XLEN-1:0]  a_data,
    input  logic [IDX_W-1:0] b_idx,
    input  logic             b_sp_ctx,
    input  logic             b_narrow,
    input  logic             b_pc,
    output logic [XLEN-1:0]  b_data
);

    localparam int NUM_RD = 2;

    wr_req_t            wreq;
    rd_req_t            rreq [NUM_RD];
    word_t              rdat [NUM_RD];
    logic [NUM_GPR-1:0] gpr_we;
    logic               sp_we;
    word_t              wr_val;
    gpr_bank_t          gpr_q;
    word_t              sp_q;

    assign wreq = '{en: wr_en, idx: wr_idx, sp_ctx: wr_sp_ctx,
                    narrow: wr_narrow, data: wr_data};
    assign rreq[0] = '{idx: a_idx, sp_ctx: a_sp_ctx, narrow: a_narrow, pc: a_pc};
    assign rreq[1] = '{idx: b_idx, sp_ctx: b_sp_ctx, narrow: b_narrow, pc: b_pc};

    gp_regfile_wr_decode u_dec (
        .clk    (clk),
        .rst    (rst),
        .req    (wreq),
        .gpr_we (gpr_we),
        .sp_we  (sp_we),
        .wr_val (wr_val)
    );

    gp_regfile_storage u_store (
        .clk    (clk),
        .rst    (rst),
        .gpr_we (gpr_we),
        .sp_we  (sp_we),
        .narrow (wr_narrow),
        .wr_val (wr_val),
        .gpr_q  (gpr_q),
        .sp_q   (sp_q)
    );

    for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
        gp_regfile_rd_port u_port (
            .clk      (clk),
            .rst      (rst),
            .req      (rreq[p]),
            .gpr_q    (gpr_q),
            .sp_q     (sp_q),
            .pc_value (pc_value),
            .data     (rdat[p])
        );
    end

    assign a_data = rdat[0];
    assign b_data = rdat[1];

    // Same selects on both ports give the same data.
    p_ports_agree_r10: assert property (@(posedge clk) disable iff (rst)
        (rreq[0] == rreq[1]) |-> a_data == b_data);

endmodule

// File: tb/gp_regfile_test.sv
`timescale 1ns/1ps
module gp_regfile_test;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en, wr_sp_ctx, wr_narrow;
    logic [4:0]  wr_idx;
    logic [63:0] wr_data, pc_value;
    logic [4:0]  a_idx, b_idx;
    logic        a_sp_ctx, a_narrow, a_pc, b_sp_ctx, b_narrow, b_pc;
    logic [63:0] a_data, b_data;

    int tests = 0;
    int fails = 0;
    bit done  = 0;

    logic [63:0] m_gpr [31];
    logic [63:0] m_sp;

    always #2.5 clk = ~clk;

    gp_regfile uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_sp_ctx(wr_sp_ctx),
        .wr_narrow(wr_narrow), .wr_data(wr_data), .pc_value(pc_value),
        .a_idx(a_idx), .a_sp_ctx(a_sp_ctx), .a_narrow(a_narrow), .a_pc(a_pc), .a_data(a_data),
        .b_idx(b_idx), .b_sp_ctx(b_sp_ctx), .b_narrow(b_narrow), .b_pc(b_pc), .b_data(b_data)
    );

    function automatic logic [63:0] model_read(input logic [4:0] idx, input logic spc,
                                               input logic nar, input logic pc);
        logic [63:0] v;
        if (pc)             v = pc_value;
        else if (idx == 31) v = spc ? m_sp : 64'd0;
        else                v = m_gpr[idx];
        if (nar) v[63:32] = 32'd0;
        return v;
    endfunction

    task automatic compare(input string tag, input string port,
                           input logic [63:0] got, input logic [63:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s port %s: got %h expected %h", tag, port, got, exp);
        end
    endtask

    // One cycle: drive at falling edge, compare 1 ns later, update model after rising edge.
    task automatic step(input string tag, input logic r,
                        input logic we, input logic [4:0] wi, input logic wsp,
                        input logic wn, input logic [63:0] wd,
                        input logic [4:0] ai, input logic asp, input logic an, input logic ap,
                        input logic [4:0] bi, input logic bsp, input logic bn, input logic bp);
        @(negedge clk);
        rst = r; wr_en = we; wr_idx = wi; wr_sp_ctx = wsp; wr_narrow = wn; wr_data = wd;
        a_idx = ai; a_sp_ctx = asp; a_narrow = an; a_pc = ap;
        b_idx = bi; b_sp_ctx = bsp; b_narrow = bn; b_pc = bp;
        pc_value = {$urandom, $urandom};
        #1;
        if (!r) begin
            compare(tag, "A", a_data, model_read(ai, asp, an, ap));
            compare(tag, "B", b_data, model_read(bi, bsp, bn, bp));
        end
        @(posedge clk);
        if (r) begin
            for (int i = 0; i < 31; i++) m_gpr[i] = 64'd0;
            m_sp = 64'd0;
        end else if (we) begin
            logic [63:0] v;
            v = wn ? {32'd0, wd[31:0]} : wd;
            if (wi < 31)  m_gpr[wi] = v;
            else if (wsp) m_sp = v;
        end
    endtask

    task automatic do_reset();
        repeat (3) step("R1", 1'b1, 1'b0, 5'd0, 1'b0, 1'b0, 64'd0,
                        5'd0, 1'b0, 1'b0, 1'b0, 5'd0, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic read_all(input string tag);
        for (int i = 0; i < 32; i++)
            step(tag, 1'b0, 1'b0, 5'd0, 1'b0, 1'b0, 64'd0,
                 5'(i), 1'b1, 1'b0, 1'b0, 5'(31 - i), 1'b1, 1'b1, 1'b0);
    endtask

    initial begin
        for (int i = 0; i < 31; i++) m_gpr[i] = 'x;
        m_sp = 'x;
        rst = 1'b1;
        wr_en = 0; wr_idx = 0; wr_sp_ctx = 0; wr_narrow = 0; wr_data = 0; pc_value = 0;
        a_idx = 0; a_sp_ctx = 0; a_narrow = 0; a_pc = 0;
        b_idx = 0; b_sp_ctx = 0; b_narrow = 0; b_pc = 0;

        // R1: reset state of every register and the stack pointer
        do_reset();
        read_all("R1");

        // R2: wide writes to every GPR, read back next cycle
        for (int i = 0; i < 31; i++)
            step("R2", 1'b0, 1'b1, 5'(i), 1'b0, 1'b0, {32'hA5A50000 | 32'(i), 32'h0F0F0000 | 32'(i)},
                 5'(i), 1'b0, 1'b0, 1'b0, 5'((i + 30) % 31), 1'b0, 1'b0, 1'b0);
        read_all("R2");

        // R3: narrow write clears upper half
        step("R3", 1'b0, 1'b1, 5'd7, 1'b0, 1'b1, 64'hFFFF_FFFF_1234_5678,
             5'd7, 1'b0, 1'b0, 1'b0, 5'd7, 1'b0, 1'b1, 1'b0);
        step("R3", 1'b0, 1'b0, 5'd0, 1'b0, 1'b0, 64'd0,
             5'd7, 1'b0, 1'b0, 1'b0, 5'd7, 1'b0, 1'b1, 1'b0);

        // R4: narrow read of a full-width value
        step("R4", 1'b0, 1'b0, 5'd0, 1'b0, 1'b0, 64'd0,
             5'd3, 1'b0, 1'b1, 1'b0, 5'd3, 1'b0, 1'b0, 1'b0);

        // R5: zero-source write is dropped and zero reads back
        step("R5", 1'b0, 1'b1, 5'd31, 1'b0, 1'b0, 64'hDEAD_BEEF_CAFE_F00D,
             5'd31, 1'b0, 1'b0, 1'b0, 5'd31, 1'b1, 1'b0, 1'b0);
        read_all("R5");

        // R6: stack pointer separate from GPRs
        step("R6", 1'b0, 1'b1, 5'd31, 1'b1, 1'b0, 64'h0000_7FFF_FFFF_FFF0,
             5'd31, 1'b1, 1'b0, 1'b0, 5'd30, 1'b0, 1'b0, 1'b0);
        step("R6", 1'b0, 1'b1, 5'd30, 1'b1, 1'b0, 64'h1111_2222_3333_4444,
             5'd31, 1'b1, 1'b0, 1'b0, 5'd31, 1'b0, 1'b0, 1'b0);
        step("R6", 1'b0, 1'b1, 5'd31, 1'b1, 1'b1, 64'h9999_8888_0000_0040,
             5'd31, 1'b1, 1'b0, 1'b0, 5'd30, 1'b1, 1'b0, 1'b0);
        read_all("R6");

        // R7: program counter reads, wide and narrow, while writes go on
        for (int i = 0; i < 8; i++)
            step("R7", 1'b0, 1'b1, 5'(i * 4), 1'(i), 1'b0, {$urandom, $urandom},
                 5'(i), 1'b0, 1'b0, 1'b1, 5'(i), 1'b0, 1'b1, 1'b1);

        // R8: write data presented with enable low changes nothing
        for (int i = 0; i < 32; i++)
            step("R8", 1'b0, 1'b0, 5'(i), 1'b1, 1'(i), 64'hBAD0_BAD0_BAD0_BAD0,
                 5'(i), 1'b1, 1'b0, 1'b0, 5'(i), 1'b0, 1'b0, 1'b0);
        read_all("R8");

        // R9: same-cycle read of the register being written sees the old value
        step("R9", 1'b0, 1'b1, 5'd12, 1'b0, 1'b0, 64'h0123_4567_89AB_CDEF,
             5'd12, 1'b0, 1'b0, 1'b0, 5'd12, 1'b0, 1'b1, 1'b0);
        step("R9", 1'b0, 1'b1, 5'd12, 1'b0, 1'b0, 64'hFEDC_BA98_7654_3210,
             5'd12, 1'b0, 1'b0, 1'b0, 5'd12, 1'b0, 1'b1, 1'b0);
        step("R9", 1'b0, 1'b1, 5'd31, 1'b1, 1'b0, 64'h5555_AAAA_5555_AAAA,
             5'd31, 1'b1, 1'b0, 1'b0, 5'd12, 1'b0, 1'b0, 1'b0);

        // R10: independent random traffic on both ports
        for (int i = 0; i < 3000; i++)
            step("R10", 1'b0, 1'($urandom), 5'($urandom), 1'($urandom), 1'($urandom),
                 {$urandom, $urandom},
                 5'($urandom), 1'($urandom), 1'($urandom), ($urandom % 8) == 0,
                 5'($urandom), 1'($urandom), 1'($urandom), ($urandom % 8) == 0);

        // R1: reset after traffic clears everything again
        do_reset();
        read_all("R1");

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule